// File: doc/BRIEF.md
# Soft Mute Attenuator with Zero-Run Flags

This block sits in a digital audio path between the input sample stage and the interpolation filters. It scales the left and right sample words by one shared gain coefficient. When the mute request is held high, the coefficient falls step by step to zero. When the request is released, it climbs back to full scale. Because the coefficient moves one step at a time, muting never produces a click.

The block also drives one flag per channel for an external analog mute switch. A channel's flag is high whenever the shared coefficient sits at zero. It is also high when that channel alone has delivered a long unbroken run of zero-valued samples. The two channels keep separate run counters, so one silent channel can be flagged while the other plays.

Every output is registered one clock after the sample strobe. Reset is synchronous and active high.

Top module: `soft_mute_core`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears its state. After that edge, `out_valid` is 0, both sample outputs are 0, the gain is 0 and both zero-run counters are 0. Because the gain is 0, both flags read 1.
- R2: `out_valid` equals the value `in_valid` had at the previous clock edge. Sample outputs and flags change only on an edge where `in_valid` is 1; on any other edge they hold.
- R3: For an accepted sample x, where x is a two's-complement signed value, the registered output is floor(x·g / 2^GAIN_W). Here g is the gain before this sample's ramp step, and the full product is kept before truncation. With defaults, GAIN_W is 10, so g = 0 gives an output of 0.
- R4: With `mute_req` = 1, each accepted sample lowers the gain by one. The gain stops at 0.
- R5: With `mute_req` = 0, each accepted sample raises the gain by one. The gain stops at 2^GAIN_W − 1, which is 1023 with defaults.
- R6: On an edge where `in_valid` is 0, the gain does not change, whatever `mute_req` is.
- R7: Whenever the gain after a sample's step is 0, both flags are 1 in the same cycle as that sample's output.
- R8: A channel's flag is 1 once that channel has received ZERO_RUN consecutive zero samples (default 8192). Only accepted samples are counted. After ZERO_RUN − 1 zero samples, the zero-run condition alone does not raise the flag.
- R9: A nonzero sample on a channel resets that channel's run count at once. Its flag then reads 0 unless the gain after that step is 0.
- R10: The run counter saturates. A zero run of any length beyond ZERO_RUN, including one longer than twice ZERO_RUN, keeps the flag high.
- R11: The left and right run counters and flags are independent. A zero run on one channel has no effect on the other channel's flag or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe; one stereo pair per high cycle |
| in_left | input | DATA_W | Left sample, two's complement |
| in_right | input | DATA_W | Right sample, two's complement |
| mute_req | input | 1 | 1 ramps the gain toward zero, 0 ramps it toward full scale |
| out_valid | output | 1 | Registered strobe for the scaled pair |
| out_left | output | DATA_W | Scaled left sample |
| out_right | output | DATA_W | Scaled right sample |
| flag_left | output | 1 | Left mute flag |
| flag_right | output | 1 | Right mute flag |

## Verification
The properties take for granted that `in_valid` is low while reset is asserted. This keeps the strobe pipeline check meaningful from the first free cycle. The properties also assume that `mute_req` and the sample words are stable at each rising edge.

The stimulus drives every input on the falling edge and holds `in_valid` low through each reset pulse. It sweeps the gain through its whole range in both directions, with sample values that include the most negative and most positive words. The zero-run properties rely only on what each channel sees. The stimulus therefore builds runs on one channel while the other carries nonzero data, and it runs past twice the threshold to expose a counter that wraps.

// File: rtl/smute_pkg.sv
package smute_pkg;

  localparam int unsigned NUM_CH = 2;

  typedef enum logic {
    CH_LEFT  = 1'b0,
    CH_RIGHT = 1'b1
  } chan_e;

endpackage

// File: rtl/smute_gain_ramp.sv
module smute_gain_ramp #(
  parameter int unsigned GAIN_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_en,
  input  logic              mute_req,
  output logic [GAIN_W-1:0] gain_q,
  output logic [GAIN_W-1:0] gain_nxt
);

  localparam logic [GAIN_W-1:0] GMAX = '1;

  always_comb begin
    gain_nxt = gain_q;
    if (step_en) begin
      if (mute_req) begin
        if (gain_q != '0) gain_nxt = gain_q - 1'b1;
      end else begin
        if (gain_q != GMAX) gain_nxt = gain_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) gain_q <= '0;
    else     gain_q <= gain_nxt;
  end

endmodule

// File: rtl/smute_channel.sv
module smute_channel #(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned GAIN_W   = 10,
  parameter int unsigned ZERO_RUN = 8192
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     smp_en,
  input  logic signed [DATA_W-1:0] smp_in,
  input  logic [GAIN_W-1:0]        gain_cur,
  input  logic                     gain_zero_nxt,
  output logic signed [DATA_W-1:0] smp_out,
  output logic                     flag_out
);

  localparam int unsigned PW = DATA_W + GAIN_W + 1;
  localparam int unsigned CW = $clog2(ZERO_RUN + 1);
  localparam logic [CW-1:0] RUN_TOP = CW'(ZERO_RUN);

  logic signed [PW-1:0]     prod;
  logic signed [DATA_W-1:0] scaled;
  logic [CW-1:0]            run_q, run_nxt;
  logic                     is_zero;

  assign prod    = PW'(smp_in) * PW'($signed({1'b0, gain_cur}));
  assign scaled  = DATA_W'(prod >>> GAIN_W);
  assign is_zero = (smp_in == '0);

  always_comb begin
    if (!is_zero)               run_nxt = '0;
    else if (run_q == RUN_TOP)  run_nxt = run_q;
    else                        run_nxt = run_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q    <= '0;
      smp_out  <= '0;
      flag_out <= 1'b1;
    end else if (smp_en) begin
      run_q    <= run_nxt;
      smp_out  <= scaled;
      flag_out <= gain_zero_nxt || (run_nxt == RUN_TOP);
    end
  end

endmodule

// File: rtl/soft_mute_core.sv
module soft_mute_core #(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned GAIN_W   = 10,
  parameter int unsigned ZERO_RUN = 8192
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_left,
  input  logic signed [DATA_W-1:0] in_right,
  input  logic                     mute_req,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_left,
  output logic signed [DATA_W-1:0] out_right,
  output logic                     flag_left,
  output logic                     flag_right
);

  import smute_pkg::*;

  logic [GAIN_W-1:0]        gain_q, gain_nxt;
  logic                     gain_zero_nxt;
  logic signed [DATA_W-1:0] ch_in   [NUM_CH];
  logic signed [DATA_W-1:0] ch_out  [NUM_CH];
  logic                     ch_flag [NUM_CH];

  smute_gain_ramp #(.GAIN_W(GAIN_W)) i_ramp (
    .clk      (clk),
    .rst      (rst),
    .step_en  (in_valid),
    .mute_req (mute_req),
    .gain_q   (gain_q),
    .gain_nxt (gain_nxt)
  );

  assign gain_zero_nxt = (gain_nxt == '0);
  assign ch_in[CH_LEFT]  = in_left;
  assign ch_in[CH_RIGHT] = in_right;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    smute_channel #(
      .DATA_W   (DATA_W),
      .GAIN_W   (GAIN_W),
      .ZERO_RUN (ZERO_RUN)
    ) i_ch (
      .clk           (clk),
      .rst           (rst),
      .smp_en        (in_valid),
      .smp_in        (ch_in[c]),
      .gain_cur      (gain_q),
      .gain_zero_nxt (gain_zero_nxt),
      .smp_out       (ch_out[c]),
      .flag_out      (ch_flag[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= in_valid;
  end

  assign out_left   = ch_out[CH_LEFT];
  assign out_right  = ch_out[CH_RIGHT];
  assign flag_left  = ch_flag[CH_LEFT];
  assign flag_right = ch_flag[CH_RIGHT];

endmodule

// File: rtl/smute_chk.sv
module smute_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned GAIN_W = 10
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     in_valid,
  input logic signed [DATA_W-1:0] in_left,
  input logic signed [DATA_W-1:0] in_right,
  input logic                     mute_req,
  input logic                     out_valid,
  input logic signed [DATA_W-1:0] out_left,
  input logic signed [DATA_W-1:0] out_right,
  input logic                     flag_left,
  input logic                     flag_right,
  input logic [GAIN_W-1:0]        gain
);

  localparam logic [GAIN_W-1:0] GMAX = '1;

  // R2
  strobe_on_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R2
  strobe_off_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R3
  silent_out_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && gain == '0) |=> (out_left == '0 && out_right == '0));

  // R4
  gain_down_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mute_req && gain != '0) |=> (gain == $past(gain) - 1'b1));

  // R5
  gain_up_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !mute_req && gain != GMAX) |=> (gain == $past(gain) + 1'b1));

  // R6
  gain_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(gain));

  // R7
  zero_gain_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (gain == '0) |-> (flag_left && flag_right));

  // R9
  left_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_left != '0) |=> (flag_left == (gain == '0)));

  // R9
  right_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_right != '0) |=> (flag_right == (gain == '0)));

endmodule

bind soft_mute_core smute_chk #(.DATA_W(DATA_W), .GAIN_W(GAIN_W)) i_smute_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_left    (in_left),
  .in_right   (in_right),
  .mute_req   (mute_req),
  .out_valid  (out_valid),
  .out_left   (out_left),
  .out_right  (out_right),
  .flag_left  (flag_left),
  .flag_right (flag_right),
  .gain       (gain_q)
);

// File: tb/test_soft_mute_core.sv
`timescale 1ns/1ps
module test_soft_mute_core;

  localparam int DW = 16;
  localparam int GW = 10;
  localparam int ZR = 8192;
  localparam int GMAX = (1 << GW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [DW-1:0] in_left = '0;
  logic signed [DW-1:0] in_right = '0;
  logic mute_req = 1'b0;
  logic out_valid;
  logic signed [DW-1:0] out_left, out_right;
  logic flag_left, flag_right;

  int checks = 0;
  int errors = 0;

  int m_gain, m_run_l, m_run_r, m_out_l, m_out_r, m_vld;
  int m_flag_l, m_flag_r;

  always #5 clk = ~clk;

  soft_mute_core i_soft_mute_core (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_left(in_left),
    .in_right(in_right), .mute_req(mute_req), .out_valid(out_valid),
    .out_left(out_left), .out_right(out_right),
    .flag_left(flag_left), .flag_right(flag_right)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    check("R2", "out_valid", int'(out_valid), m_vld);
    check(tag, "out_left", int'(out_left), m_out_l);
    check(tag, "out_right", int'(out_right), m_out_r);
    check(tag, "flag_left", int'(flag_left), m_flag_l);
    check(tag, "flag_right", int'(flag_right), m_flag_r);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    m_gain = 0; m_run_l = 0; m_run_r = 0; m_out_l = 0; m_out_r = 0;
    m_vld = 0; m_flag_l = 1; m_flag_r = 1;
    check_all("R1");
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic step(input bit v, input int l, input int r, input bit m, input string tag);
    @(negedge clk);
    in_valid = v; in_left = DW'(l); in_right = DW'(r); mute_req = m;
    m_vld = v;
    if (v) begin
      m_out_l = (l * m_gain) >>> GW;
      m_out_r = (r * m_gain) >>> GW;
      if (m) begin if (m_gain > 0) m_gain--; end
      else begin if (m_gain < GMAX) m_gain++; end
      m_run_l = (l != 0) ? 0 : ((m_run_l < ZR) ? m_run_l + 1 : ZR);
      m_run_r = (r != 0) ? 0 : ((m_run_r < ZR) ? m_run_r + 1 : ZR);
      m_flag_l = (m_gain == 0 || m_run_l >= ZR) ? 1 : 0;
      m_flag_r = (m_gain == 0 || m_run_r >= ZR) ? 1 : 0;
    end
    @(posedge clk); #1;
    check_all(tag);
  endtask

  function automatic int pat(input int i, input int k);
    int v;
    if (i % 97 == 0) return -32768;
    if (i % 89 == 0) return 32767;
    v = ((i * k + 12345) % 65536) - 32768;
    return (v == 0) ? 1 : v;
  endfunction

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R5, R3: ramp up from zero across the full gain range
    for (int i = 0; i < 1100; i++) step(1'b1, pat(i, 7919), pat(i, 131), 1'b0, "R5");
    // R6: idle with mute requested, gain must hold
    for (int i = 0; i < 20; i++) step(1'b0, 0, 0, 1'b1, "R6");
    step(1'b1, 32767, -32768, 1'b0, "R6");
    step(1'b1, -1, 1, 1'b0, "R3");
    // R4, R7: ramp down to zero and stay there
    for (int i = 0; i < 1100; i++) step(1'b1, pat(i, 4099), pat(i, 613), 1'b1, "R4");
    step(1'b1, 32767, -32768, 1'b1, "R7");
    // reversal mid-ramp
    for (int i = 0; i < 300; i++) step(1'b1, pat(i, 31), pat(i, 17), (i % 3 == 0), "R3");
    for (int i = 0; i < 1100; i++) step(1'b1, pat(i, 29), pat(i, 23), 1'b0, "R5");
    // R8, R11: left zero run up to threshold, right keeps playing
    for (int i = 0; i < ZR - 1; i++) step(1'b1, 0, pat(i, 53), 1'b0, "R11");
    step(1'b1, 0, 77, 1'b0, "R8");
    // R10: long run past twice the threshold
    for (int i = 0; i < ZR + 200; i++) step(1'b1, 0, pat(i, 71), 1'b0, "R10");
    // R9: nonzero clears the left flag at once
    step(1'b1, 5, 9, 1'b0, "R9");
    step(1'b1, 0, 9, 1'b0, "R9");
    // R11: right zero run while left plays
    for (int i = 0; i < ZR + 5; i++) step(1'b1, pat(i, 37), 0, 1'b0, "R11");
    step(1'b1, 3, -3, 1'b0, "R9");
    // R1: synchronous reset mid-stream
    do_reset();
    step(1'b1, 1000, -1000, 1'b0, "R1");
    step(1'b1, 1000, -1000, 1'b0, "R3");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule